// File: doc/BRIEF.md
# Per-Master Aperture Address Decoder

This block sits beside a multi-master interconnect and decides, for every master independently, which slave an address goes to and what address that slave sees. Each master's 32-bit space is cut into sixteen 256 MB apertures. Address bits [31:28] pick the aperture. For each aperture a 4-bit slave code selects the target and a 4-bit nibble replaces the top four address bits.

Software programs the tables through a simple register port. The write is single-cycle, and the read data is combinational from the register address. Table writes land in pending copies. A commit write then moves one master's complete table into the active copy in one step, so the interconnect never decodes with a half-written table. Master 0 also has a boot-mirror control that forces the lowest aperture onto the ROM while it is set. A separate extension register, which has its own commit, supplies extra upper address bits. At its reset value of zero, addresses are not extended.

Top module: `apdec_top`

## Requirements
- R1: After reset, every master reads slave-select words 0x77777777, offset word 0 0xFEDCBA98, offset word 1 0x76543210, and master 0 boot bits 2'b01. The extension register reads zero.
- R2: Master m's registers sit at byte address m*0x20 plus a group offset. The offsets are: slave-select low word 0x00, slave-select high word 0x04, offset low word 0x08, offset high word 0x0C, master 0 boot register 0x10, commit 0x14. Reads return the pending value, and the commit register reads zero.
- R3: Writes to table words do not change decode until that master is committed.
- R4: Writing exactly 1 to a master's commit register copies all four of its pending words to the active tables on that clock edge. Any other value is ignored. A commit affects only the addressed master.
- R5: The aperture is address bits [31:28]. Nibble i of a low word serves aperture i, and nibble i of a high word serves aperture 8+i.
- R6: The output address is {extension value, offset nibble of the aperture, input address bits [27:0]}, 40 bits wide.
- R7: Slave codes 11 to 15 decode to slave 0. The error flag is set exactly when the output slave is 0.
- R8: While master 0's boot bits [1:0] are nonzero, master 0's aperture 0 decodes to slave 5 (ROM) with offset nibble 0. A boot write takes effect on the next clock edge, without a commit.
- R9: The extension register is 8 bits at byte address 0x180, and its commit register is at 0x194. It commits the same way a master commits. While the active extension value is zero, output bits [39:32] are zero.
- R10: Writes to unmapped addresses are ignored, and unmapped addresses read zero. A master index of 12 or more decodes to slave 0 with the error flag set, and the address passes through as {extension, input address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| dec_master | input | 4 | Master index to decode for |
| dec_addr | input | 32 | Address issued by that master |
| dec_slave | output | 4 | Selected slave code |
| dec_out_addr | output | 40 | Remapped, extended address |
| dec_err | output | 1 | Decode error: no slave or unused code |

## Verification
A corrupted active table shows up on the very next decode of the affected aperture, in the same cycle, as a wrong slave code or a wrong top address nibble. A pending word that is captured wrongly shows up immediately on read-back. A wrong commit shows up only later, at the decode ports after the commit edge, or in decodes that change when they should not have. A stuck boot mirror shows only on master 0's aperture 0, so the bench exercises that aperture both before and after the boot bits are cleared. The bench checks read data and decode outputs after each randomized transaction.

// File: rtl/apdec_pkg.sv
package apdec_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned NIB_W       = 4;
  localparam int unsigned NUM_AP      = 16;
  localparam int unsigned TAB_W       = NUM_AP * NIB_W;
  localparam int unsigned GRP_OFF_W   = 5;

  // register offsets inside one master group
  localparam logic [GRP_OFF_W-1:0] OFF_SEL_LO = 5'h00;
  localparam logic [GRP_OFF_W-1:0] OFF_SEL_HI = 5'h04;
  localparam logic [GRP_OFF_W-1:0] OFF_OFS_LO = 5'h08;
  localparam logic [GRP_OFF_W-1:0] OFF_OFS_HI = 5'h0C;
  localparam logic [GRP_OFF_W-1:0] OFF_BOOT   = 5'h10;
  localparam logic [GRP_OFF_W-1:0] OFF_COMMIT = 5'h14;

  localparam logic [DATA_W-1:0] COMMIT_KEY  = 32'd1;
  localparam logic [DATA_W-1:0] RST_SEL     = 32'h7777_7777;
  localparam logic [DATA_W-1:0] RST_OFS_LO  = 32'hFEDC_BA98;
  localparam logic [DATA_W-1:0] RST_OFS_HI  = 32'h7654_3210;
  localparam logic [1:0]        RST_BOOT    = 2'b01;

  localparam logic [NIB_W-1:0]  SLV_NONE    = 4'd0;
  localparam logic [NIB_W-1:0]  SLV_ROM     = 4'd5;
  localparam logic [NIB_W-1:0]  SLV_LAST    = 4'd10;
endpackage

// File: rtl/apdec_master_regs.sv
module apdec_master_regs
  import apdec_pkg::*;
#(
  parameter bit HAS_BOOT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [GRP_OFF_W-1:0] off,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic [TAB_W-1:0]     act_sel,
  output logic [TAB_W-1:0]     act_ofs,
  output logic                 boot_on
);
  logic [DATA_W-1:0] sel_lo_q, sel_hi_q, ofs_lo_q, ofs_hi_q;
  logic [DATA_W-1:0] sel_lo_n, sel_hi_n, ofs_lo_n, ofs_hi_n;
  logic [TAB_W-1:0]  act_sel_q, act_ofs_q, act_sel_n, act_ofs_n;
  logic [1:0]        boot_q, boot_n;
  logic              commit_en;

  assign commit_en = wr_en && (off == OFF_COMMIT) && (wdata == COMMIT_KEY);

  always_comb begin
    sel_lo_n  = sel_lo_q;
    sel_hi_n  = sel_hi_q;
    ofs_lo_n  = ofs_lo_q;
    ofs_hi_n  = ofs_hi_q;
    boot_n    = boot_q;
    act_sel_n = act_sel_q;
    act_ofs_n = act_ofs_q;
    if (wr_en) begin
      case (off)
        OFF_SEL_LO: sel_lo_n = wdata;
        OFF_SEL_HI: sel_hi_n = wdata;
        OFF_OFS_LO: ofs_lo_n = wdata;
        OFF_OFS_HI: ofs_hi_n = wdata;
        OFF_BOOT:   if (HAS_BOOT) boot_n = wdata[1:0];
        default:    ;
      endcase
    end
    if (commit_en) begin
      act_sel_n = {sel_hi_q, sel_lo_q};
      act_ofs_n = {ofs_hi_q, ofs_lo_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo_q  <= RST_SEL;
      sel_hi_q  <= RST_SEL;
      ofs_lo_q  <= RST_OFS_LO;
      ofs_hi_q  <= RST_OFS_HI;
      boot_q    <= HAS_BOOT ? RST_BOOT : 2'b00;
      act_sel_q <= {RST_SEL, RST_SEL};
      act_ofs_q <= {RST_OFS_HI, RST_OFS_LO};
    end else begin
      if (wr_en) begin
        sel_lo_q <= sel_lo_n;
        sel_hi_q <= sel_hi_n;
        ofs_lo_q <= ofs_lo_n;
        ofs_hi_q <= ofs_hi_n;
        boot_q   <= boot_n;
      end
      if (commit_en) begin
        act_sel_q <= act_sel_n;
        act_ofs_q <= act_ofs_n;
      end
    end
  end

  always_comb begin
    case (off)
      OFF_SEL_LO: rd_data = sel_lo_q;
      OFF_SEL_HI: rd_data = sel_hi_q;
      OFF_OFS_LO: rd_data = ofs_lo_q;
      OFF_OFS_HI: rd_data = ofs_hi_q;
      OFF_BOOT:   rd_data = HAS_BOOT ? {{(DATA_W-2){1'b0}}, boot_q} : '0;
      default:    rd_data = '0;
    endcase
  end

  assign act_sel = act_sel_q;
  assign act_ofs = act_ofs_q;
  assign boot_on = |boot_q;

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> ($stable(act_sel) && $stable(act_ofs)));
  a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (act_sel == $past({sel_hi_q, sel_lo_q})) && (act_ofs == $past({ofs_hi_q, ofs_lo_q})));
endmodule

// File: rtl/apdec_ext_regs.sv
module apdec_ext_regs
  import apdec_pkg::*;
#(
  parameter int unsigned EXT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [GRP_OFF_W-1:0] off,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic [EXT_W-1:0]     ext_act
);
  logic [EXT_W-1:0] pend_q, pend_n, act_q, act_n;
  logic             pend_en, commit_en;

  assign pend_en   = wr_en && (off == OFF_SEL_LO);
  assign commit_en = wr_en && (off == OFF_COMMIT) && (wdata == COMMIT_KEY);

  always_comb begin
    pend_n = pend_q;
    act_n  = act_q;
    if (pend_en)   pend_n = wdata[EXT_W-1:0];
    if (commit_en) act_n  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (pend_en)   pend_q <= pend_n;
      if (commit_en) act_q  <= act_n;
    end
  end

  assign rd_data = (off == OFF_SEL_LO) ? {{(DATA_W-EXT_W){1'b0}}, pend_q} : '0;
  assign ext_act = act_q;

  a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> $stable(ext_act));
endmodule

// File: rtl/apdec_lookup.sv
module apdec_lookup
  import apdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXT_W  = 8
) (
  input  logic [TAB_W-1:0]        sel_tab,
  input  logic [TAB_W-1:0]        ofs_tab,
  input  logic                    mirror,
  input  logic                    master_ok,
  input  logic [EXT_W-1:0]        ext,
  input  logic [ADDR_W-1:0]       addr,
  output logic [NIB_W-1:0]        slave,
  output logic [ADDR_W+EXT_W-1:0] out_addr,
  output logic                    err
);
  localparam int unsigned LOW_W = ADDR_W - NIB_W;

  logic [NIB_W-1:0] ap, code, nib;

  assign ap = addr[ADDR_W-1 -: NIB_W];

  always_comb begin
    code = sel_tab[ap*NIB_W +: NIB_W];
    nib  = ofs_tab[ap*NIB_W +: NIB_W];
    if (mirror && (ap == '0)) begin
      code = SLV_ROM;
      nib  = '0;
    end
    if (!master_ok) begin
      slave    = SLV_NONE;
      out_addr = {ext, addr};
    end else begin
      slave    = (code > SLV_LAST) ? SLV_NONE : code;
      out_addr = {ext, nib, addr[LOW_W-1:0]};
    end
    err = (slave == SLV_NONE);
  end
endmodule

// File: rtl/apdec_top.sv
module apdec_top
  import apdec_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 12,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned EXT_W       = 8,
  parameter int unsigned CFG_ADDR_W  = 9,
  parameter int unsigned MIDX_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [CFG_ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  output logic [DATA_W-1:0]       cfg_rdata,
  input  logic [MIDX_W-1:0]       dec_master,
  input  logic [ADDR_W-1:0]       dec_addr,
  output logic [NIB_W-1:0]        dec_slave,
  output logic [ADDR_W+EXT_W-1:0] dec_out_addr,
  output logic                    dec_err
);
  localparam int unsigned GRP_W   = CFG_ADDR_W - GRP_OFF_W;
  localparam int unsigned EXT_GRP = NUM_MASTERS;

  logic [GRP_W-1:0]     grp;
  logic [GRP_OFF_W-1:0] off;
  logic [DATA_W-1:0]    rd_m [NUM_MASTERS];
  logic [TAB_W-1:0]     sel_m [NUM_MASTERS];
  logic [TAB_W-1:0]     ofs_m [NUM_MASTERS];
  logic [NUM_MASTERS-1:0] boot_m;
  logic [DATA_W-1:0]    rd_ext;
  logic [EXT_W-1:0]     ext_act;
  logic                 ext_wr;

  assign grp = cfg_addr[CFG_ADDR_W-1:GRP_OFF_W];
  assign off = cfg_addr[GRP_OFF_W-1:0];

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    logic grp_wr;
    assign grp_wr = cfg_wr && (grp == GRP_W'(m));
    apdec_master_regs #(.HAS_BOOT(m == 0)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (grp_wr),
      .off     (off),
      .wdata   (cfg_wdata),
      .rd_data (rd_m[m]),
      .act_sel (sel_m[m]),
      .act_ofs (ofs_m[m]),
      .boot_on (boot_m[m])
    );
  end

  assign ext_wr = cfg_wr && (grp == GRP_W'(EXT_GRP));

  apdec_ext_regs #(.EXT_W(EXT_W)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ext_wr),
    .off     (off),
    .wdata   (cfg_wdata),
    .rd_data (rd_ext),
    .ext_act (ext_act)
  );

  always_comb begin
    cfg_rdata = '0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (grp == GRP_W'(m)) cfg_rdata = rd_m[m];
    if (grp == GRP_W'(EXT_GRP)) cfg_rdata = rd_ext;
  end

  logic             master_ok;
  logic [TAB_W-1:0] sel_cur, ofs_cur;
  logic             mirror_cur;

  assign master_ok = (dec_master < MIDX_W'(NUM_MASTERS));

  always_comb begin
    sel_cur    = '0;
    ofs_cur    = '0;
    mirror_cur = 1'b0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (dec_master == MIDX_W'(m)) begin
        sel_cur    = sel_m[m];
        ofs_cur    = ofs_m[m];
        mirror_cur = boot_m[m];
      end
  end

  apdec_lookup #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_lookup (
    .sel_tab   (sel_cur),
    .ofs_tab   (ofs_cur),
    .mirror    (mirror_cur),
    .master_ok (master_ok),
    .ext       (ext_act),
    .addr      (dec_addr),
    .slave     (dec_slave),
    .out_addr  (dec_out_addr),
    .err       (dec_err)
  );

  a_r7_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    dec_slave <= SLV_LAST);
  a_r7_err_iff_none: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err == (dec_slave == SLV_NONE));
  a_r8_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_m[0] && dec_master == '0 && dec_addr[ADDR_W-1 -: NIB_W] == '0)
      |-> (dec_slave == SLV_ROM && dec_out_addr[ADDR_W-1 -: NIB_W] == '0));
  a_r9_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_act == '0) |-> (dec_out_addr[ADDR_W+EXT_W-1:ADDR_W] == '0));
  a_r6_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_addr[ADDR_W-NIB_W-1:0] == dec_addr[ADDR_W-NIB_W-1:0]);
  a_r10_bad_master: assert property (@(posedge clk) disable iff (!rst_n)
    !master_ok |-> dec_err);
endmodule

// File: tb/apdec_top_bench.sv
module apdec_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [8:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  dec_master;
  logic [31:0] dec_addr;
  logic [3:0]  dec_slave;
  logic [39:0] dec_out_addr;
  logic        dec_err;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // model state
  logic [31:0] p_sl[12], p_sh[12], p_ol[12], p_oh[12];
  logic [63:0] a_sel[12], a_ofs[12];
  logic [1:0]  boot;
  logic [7:0]  p_ext, a_ext;

  always #5 clk = ~clk;

  apdec_top u_apdec_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_master(dec_master),
    .dec_addr(dec_addr), .dec_slave(dec_slave), .dec_out_addr(dec_out_addr),
    .dec_err(dec_err)
  );

  task automatic model_reset();
    for (int m = 0; m < 12; m++) begin
      p_sl[m] = 32'h77777777; p_sh[m] = 32'h77777777;
      p_ol[m] = 32'hFEDCBA98; p_oh[m] = 32'h76543210;
      a_sel[m] = {p_sh[m], p_sl[m]}; a_ofs[m] = {p_oh[m], p_ol[m]};
    end
    boot = 2'b01; p_ext = '0; a_ext = '0;
  endtask

  function automatic logic [31:0] model_read(input logic [8:0] a);
    int g = int'(a[8:5]);
    logic [4:0] o = a[4:0];
    if (g < 12) begin
      case (o)
        5'h00: return p_sl[g];
        5'h04: return p_sh[g];
        5'h08: return p_ol[g];
        5'h0C: return p_oh[g];
        5'h10: return (g == 0) ? {30'b0, boot} : 32'h0;
        default: return 32'h0;
      endcase
    end else if (g == 12 && o == 5'h00) return {24'b0, p_ext};
    return 32'h0;
  endfunction

  task automatic model_write(input logic [8:0] a, input logic [31:0] d);
    int g = int'(a[8:5]);
    logic [4:0] o = a[4:0];
    if (g < 12) begin
      case (o)
        5'h00: p_sl[g] = d;
        5'h04: p_sh[g] = d;
        5'h08: p_ol[g] = d;
        5'h0C: p_oh[g] = d;
        5'h10: if (g == 0) boot = d[1:0];
        5'h14: if (d == 32'd1) begin
                 a_sel[g] = {p_sh[g], p_sl[g]}; a_ofs[g] = {p_oh[g], p_ol[g]};
               end
        default: ;
      endcase
    end else if (g == 12) begin
      if (o == 5'h00) p_ext = d[7:0];
      else if (o == 5'h14 && d == 32'd1) a_ext = p_ext;
    end
  endtask

  task automatic exp_dec(input int m, input logic [31:0] a,
                         output logic [3:0] s, output logic [39:0] oa, output logic e);
    logic [3:0] ap = a[31:28];
    logic [3:0] code, nib;
    if (m >= 12) begin
      s = 4'd0; oa = {a_ext, a};
    end else begin
      code = a_sel[m][ap*4 +: 4];
      nib  = a_ofs[m][ap*4 +: 4];
      if (m == 0 && boot != 0 && ap == 0) begin code = 4'd5; nib = 4'd0; end
      s  = (code > 4'd10) ? 4'd0 : code;
      oa = {a_ext, nib, a[27:0]};
    end
    e = (s == 4'd0);
  endtask

  task automatic check32(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic chk_read(input string req, input logic [8:0] a);
    cfg_addr = a;
    #1;
    check32(req, {32'b0, cfg_rdata}, {32'b0, model_read(a)});
  endtask

  task automatic chk_dec(input string req, input int m, input logic [31:0] a);
    logic [3:0] s; logic [39:0] oa; logic e;
    dec_master = 4'(m); dec_addr = a;
    #1;
    exp_dec(m, a, s, oa, e);
    check32(req, {19'b0, dec_err, dec_slave, dec_out_addr}, {19'b0, e, s, oa});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    dec_master = '0; dec_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk_read("R1", 9'h000); chk_read("R1", 9'h004); chk_read("R1", 9'h008);
    chk_read("R1", 9'h00C); chk_read("R1", 9'h010); chk_read("R1", 9'h16C);
    chk_read("R1", 9'h180);
    // R8 boot mirror active after reset; R9 zero extension
    chk_dec("R8", 0, 32'h0123_4567);
    chk_dec("R9", 3, 32'h8000_0010);

    // R2/R3: program master 2 without commit; decode unchanged
    wr(9'h040, 32'h0000_00A1); wr(9'h044, 32'hB000_0009);
    wr(9'h048, 32'h0000_0021); wr(9'h04C, 32'h5000_0003);
    chk_read("R2", 9'h040); chk_read("R2", 9'h04C); chk_read("R2", 9'h054);
    chk_dec("R3", 2, 32'h1ABC_DEF0);
    // R4: wrong key ignored, then key 1 commits
    wr(9'h054, 32'd2);
    chk_dec("R4", 2, 32'h1ABC_DEF0);
    wr(9'h054, 32'd1);
    chk_dec("R4", 2, 32'h1ABC_DEF0);
    chk_dec("R4", 3, 32'h1ABC_DEF0);
    // R5 nibble layout: aperture 0 lo nibble 0, aperture 8 hi nibble 0, aperture 15
    chk_dec("R5", 2, 32'h0000_0004);
    chk_dec("R5", 2, 32'h8765_4321);
    chk_dec("R7", 2, 32'hF000_0000);
    chk_dec("R7", 2, 32'h2000_0000);
    chk_dec("R6", 2, 32'h8FFF_FFFF);

    // R8 boot cleared exposes programmed map; no commit needed
    wr(9'h000, 32'h1111_1112); wr(9'h014, 32'd1);
    chk_dec("R8", 0, 32'h0000_1000);
    wr(9'h010, 32'h0000_0000);
    chk_read("R8", 9'h010);
    chk_dec("R8", 0, 32'h0000_1000);
    wr(9'h010, 32'h0000_0002);
    chk_dec("R8", 0, 32'h0FFF_0000);
    chk_dec("R8", 1, 32'h0FFF_0000);
    wr(9'h010, 32'h0000_0000);

    // R9 extension commit
    wr(9'h180, 32'hFFFF_FF5A);
    chk_read("R9", 9'h180);
    chk_dec("R9", 2, 32'h8000_0000);
    wr(9'h194, 32'd1);
    chk_dec("R9", 2, 32'h8000_0000);
    wr(9'h180, 32'h0); wr(9'h194, 32'd1);
    chk_dec("R9", 4, 32'hC000_0000);

    // R10 unmapped writes / reads, bad masters
    wr(9'h018, 32'hDEAD_BEEF); wr(9'h030, 32'hDEAD_BEEF); wr(9'h1C0, 32'hDEAD_BEEF);
    chk_read("R10", 9'h018); chk_read("R10", 9'h030); chk_read("R10", 9'h1C0);
    chk_read("R10", 9'h002); chk_read("R10", 9'h184);
    chk_read("R10", 9'h020);
    chk_dec("R10", 12, 32'h3456_789A);
    chk_dec("R10", 15, 32'h0000_0000);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] g;
      logic [4:0] o;
      logic [31:0] d;
      g = 4'($urandom_range(0, 13));
      o = 5'($urandom_range(0, 7) * 4);
      d = $urandom();
      if (o == 5'h14 && $urandom_range(0, 2) != 0) d = 32'd1;
      if (o == 5'h10) d = {30'b0, 2'($urandom_range(0, 3))};
      wr({g, o}, d);
      chk_read("R2", {4'($urandom_range(0, 13)), 5'($urandom_range(0, 7) * 4)});
      chk_dec("R5", int'($urandom_range(0, 13)), $urandom());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule